// File: doc/BRIEF.md
# Registered AXI-Stream Beat Relay

The relay sits between a memory-to-stream DMA channel and a stream-to-memory DMA channel. It takes one beat at a time on its AXI-Stream sink port and latches the word, its byte-enable mask and its end-of-packet flag into a holding register. It then offers that register on its AXI-Stream source port. The holding register marks where a future processing stage will go. For now the word passes through unchanged.

A two-state controller alternates between accepting and sending. While a word is held, the sink side is closed. Once the downstream side takes the word, valid drops in the next cycle. As a result, a byte counter downstream can never count the same word twice. Packet boundaries and byte masks go out on exactly the beat that carries their data. Throughput is at most one beat every two cycles.

Top module: `axis_beat_relay`

## Requirements
- R1: A synchronous active-high reset makes `s_axis_tready` 1 and `m_axis_tvalid` 0 at the next edge. This holds even if a word was being held at the time.
- R2: A sink beat is taken at each rising edge where `s_axis_tvalid` and `s_axis_tready` are both 1. After that edge, `m_axis_tdata` equals the taken word.
- R3: In the cycle after a sink beat is taken, `m_axis_tvalid` is 1 and `s_axis_tready` is 0.
- R4: While `m_axis_tvalid` is 1 and `m_axis_tready` is 0, the next cycle keeps `m_axis_tvalid` at 1. It also leaves `m_axis_tdata`, `m_axis_tkeep` and `m_axis_tlast` unchanged.
- R5: After an edge where `m_axis_tvalid` and `m_axis_tready` are both 1, `m_axis_tvalid` is 0 and `s_axis_tready` is 1. No word is presented for a second transfer.
- R6: `m_axis_tlast` equals the `s_axis_tlast` taken with the same word.
- R7: `m_axis_tkeep` equals the `s_axis_tkeep` taken with the same word, bit for bit. Bit i qualifies byte i of the data word.
- R8: `s_axis_tready` and `m_axis_tvalid` are never 1 in the same cycle, so at most one word is held.
- R9: Under any pattern of upstream and downstream stalls, the sequence of source beats equals the sequence of sink beats in data, mask and end flag, with no loss and no repeat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_axis_tdata | input | DATA_W | Sink data word |
| s_axis_tkeep | input | DATA_W/8 | Sink byte-valid mask |
| s_axis_tlast | input | 1 | Sink end of packet |
| s_axis_tvalid | input | 1 | Sink word valid |
| s_axis_tready | output | 1 | Relay can take a sink word |
| m_axis_tdata | output | DATA_W | Source data word |
| m_axis_tkeep | output | DATA_W/8 | Source byte-valid mask |
| m_axis_tlast | output | 1 | Source end of packet |
| m_axis_tvalid | output | 1 | Source word valid |
| m_axis_tready | input | 1 | Downstream takes the source word |

## Verification
Two events can fall in the same cycle: a downstream acceptance that closes the hold state, and an upstream word that is already waiting with valid high. The bench keeps upstream valid asserted through the hold state, so the word is taken right after the sink reopens. It also raises downstream ready at random. Each cycle, a queue model predicts both ready/valid flags and the held word. Each source transfer is then compared with the front of the queue of sink transfers.

// File: rtl/axis_relay_pkg.sv
package axis_relay_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HOLD = 1'b1
  } relay_state_e;
endpackage

// File: rtl/axis_relay_ctrl.sv
module axis_relay_ctrl
  import axis_relay_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sink_valid,
  input  logic src_ready,
  output logic sink_ready,
  output logic src_valid,
  output logic capture_en
);
  relay_state_e state;

  assign capture_en = sink_valid && sink_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      sink_ready <= 1'b1;
      src_valid  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (capture_en) begin
          state      <= ST_HOLD;
          sink_ready <= 1'b0;
          src_valid  <= 1'b1;
        end
        ST_HOLD: if (src_ready) begin
          state      <= ST_IDLE;
          sink_ready <= 1'b1;
          src_valid  <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: a taken word closes the sink and opens the source
  a_r3_hold_after_take: assert property (@(posedge clk) disable iff (rst)
    capture_en |=> (src_valid && !sink_ready));

  // R5: a sent word is never presented again
  a_r5_single_send: assert property (@(posedge clk) disable iff (rst)
    (src_valid && src_ready) |=> (!src_valid && sink_ready));

  // R8: one word at most
  a_r8_one_side: assert property (@(posedge clk) disable iff (rst)
    !(sink_ready && src_valid));
endmodule

// File: rtl/axis_relay_beat_reg.sv
module axis_relay_beat_reg #(
  parameter int DATA_W = 32,
  parameter int KEEP_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              load,
  input  logic [DATA_W-1:0] d_data,
  input  logic [KEEP_W-1:0] d_keep,
  input  logic              d_last,
  output logic [DATA_W-1:0] q_data,
  output logic [KEEP_W-1:0] q_keep,
  output logic              q_last
);
  // data path left without reset; qualified by the controller's valid flag
  always_ff @(posedge clk) begin
    if (load) begin
      q_data <= d_data;
      q_keep <= d_keep;
      q_last <= d_last;
    end
  end
endmodule

// File: rtl/axis_beat_relay.sv
module axis_beat_relay #(
  parameter  int DATA_W = 32,
  localparam int KEEP_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] s_axis_tdata,
  input  logic [KEEP_W-1:0] s_axis_tkeep,
  input  logic              s_axis_tlast,
  input  logic              s_axis_tvalid,
  output logic              s_axis_tready,
  output logic [DATA_W-1:0] m_axis_tdata,
  output logic [KEEP_W-1:0] m_axis_tkeep,
  output logic              m_axis_tlast,
  output logic              m_axis_tvalid,
  input  logic              m_axis_tready
);
  logic take;

  axis_relay_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .sink_valid (s_axis_tvalid),
    .src_ready  (m_axis_tready),
    .sink_ready (s_axis_tready),
    .src_valid  (m_axis_tvalid),
    .capture_en (take)
  );

  axis_relay_beat_reg #(.DATA_W(DATA_W), .KEEP_W(KEEP_W)) u_hold (
    .clk    (clk),
    .load   (take),
    .d_data (s_axis_tdata),
    .d_keep (s_axis_tkeep),
    .d_last (s_axis_tlast),
    .q_data (m_axis_tdata),
    .q_keep (m_axis_tkeep),
    .q_last (m_axis_tlast)
  );

  // R2: taken word appears on the source
  a_r2_word_forwarded: assert property (@(posedge clk) disable iff (rst)
    (s_axis_tvalid && s_axis_tready) |=> (m_axis_tdata == $past(s_axis_tdata)));

  // R6: end flag rides with its word
  a_r6_last_with_word: assert property (@(posedge clk) disable iff (rst)
    (s_axis_tvalid && s_axis_tready) |=> (m_axis_tlast == $past(s_axis_tlast)));

  // R7: byte mask rides with its word
  a_r7_keep_with_word: assert property (@(posedge clk) disable iff (rst)
    (s_axis_tvalid && s_axis_tready) |=> (m_axis_tkeep == $past(s_axis_tkeep)));

  // R4: stalled source holds steady
  a_r4_stall_stable: assert property (@(posedge clk) disable iff (rst)
    (m_axis_tvalid && !m_axis_tready) |=>
      (m_axis_tvalid && $stable(m_axis_tdata) && $stable(m_axis_tkeep) && $stable(m_axis_tlast)));
endmodule

// File: tb/tb_axis_beat_relay.sv
module tb_axis_beat_relay;
  localparam int DW = 32;
  localparam int KW = DW / 8;
  localparam int NBEATS = 600;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst;
  logic [DW-1:0] s_data;
  logic [KW-1:0] s_keep;
  logic          s_last, s_valid, s_ready;
  logic [DW-1:0] m_data;
  logic [KW-1:0] m_keep;
  logic          m_last, m_valid, m_ready;

  axis_beat_relay #(.DATA_W(DW)) dut (
    .clk(clk), .rst(rst),
    .s_axis_tdata(s_data), .s_axis_tkeep(s_keep), .s_axis_tlast(s_last),
    .s_axis_tvalid(s_valid), .s_axis_tready(s_ready),
    .m_axis_tdata(m_data), .m_axis_tkeep(m_keep), .m_axis_tlast(m_last),
    .m_axis_tvalid(m_valid), .m_axis_tready(m_ready)
  );

  typedef logic [DW+KW:0] beat_t;   // {last, keep, data}

  int errors = 0;
  int checks = 0;
  bit done = 0;

  beat_t exp_q[$];
  bit    mdl_full;
  beat_t mdl_word;

  task automatic chk(input bit ok, input string req, input beat_t act, input beat_t exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic beat_t make_beat(input int pos, input int plen);
    logic [KW-1:0] k;
    beat_t b;
    k = '1;
    if (pos == plen - 1) k = KW'((1 << (1 + ($urandom % KW))) - 1);
    b = {(pos == plen - 1), k, DW'($urandom)};
    return b;
  endfunction

  // compare outputs with model at the negative edge
  task automatic check_outputs();
    chk(s_ready == !mdl_full, "R8/R5 s_axis_tready", beat_t'(s_ready), beat_t'(!mdl_full));
    chk(m_valid == mdl_full, "R3/R5 m_axis_tvalid", beat_t'(m_valid), beat_t'(mdl_full));
    if (mdl_full)
      chk({m_last, m_keep, m_data} == mdl_word, "R2/R6/R7 held word",
          {m_last, m_keep, m_data}, mdl_word);
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < WATCHDOG) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<%0d", wd, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int    sent = 0;
    int    got = 0;
    int    pos = 0;
    int    plen = 1;
    beat_t cur;
    bit    prev_stall = 0;
    beat_t prev_out = '0;
    int    m_pct;
    int    s_pct;
    rst = 1'b1; s_valid = 0; s_data = '0; s_keep = '0; s_last = 0; m_ready = 0;
    mdl_full = 0; mdl_word = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(s_ready == 1'b1, "R1 s_axis_tready after reset", beat_t'(s_ready), beat_t'(1));
    chk(m_valid == 1'b0, "R1 m_axis_tvalid after reset", beat_t'(m_valid), beat_t'(0));

    cur = make_beat(0, plen);
    while (got < NBEATS) begin
      // three stall regimes: heavy, none, mixed
      if (got < NBEATS / 3) begin m_pct = 40; s_pct = 40; end
      else if (got < 2 * NBEATS / 3) begin m_pct = 100; s_pct = 100; end
      else begin m_pct = 70; s_pct = 20; end
      check_outputs();
      // R4: stalled source holds steady
      if (prev_stall)
        chk(m_valid && ({m_last, m_keep, m_data} == prev_out), "R4 stall hold",
            {m_last, m_keep, m_data}, prev_out);
      // upstream keeps valid until taken (AXIS rule)
      if (!s_valid && sent < NBEATS && ($urandom % 100) < s_pct) begin
        s_valid = 1'b1;
        {s_last, s_keep, s_data} = cur;
      end
      m_ready = (($urandom % 100) < m_pct);
      prev_stall = m_valid && !m_ready;
      prev_out = {m_last, m_keep, m_data};
      // model update for the coming edge
      if (m_valid && m_ready) begin
        beat_t e;
        e = exp_q.pop_front();
        chk({m_last, m_keep, m_data} == e, "R9 sequence/R6/R7",
            {m_last, m_keep, m_data}, e);
        got++;
        mdl_full = 0;
      end
      if (s_valid && s_ready) begin
        exp_q.push_back(cur);
        mdl_full = 1;
        mdl_word = cur;
        sent++;
        pos++;
        if (pos == plen) begin pos = 0; plen = 1 + ($urandom % 7); end
        cur = make_beat(pos, plen);
        @(posedge clk);
        #1 s_valid = 1'b0;
        @(negedge clk);
      end else begin
        @(negedge clk);
      end
    end
    chk(exp_q.size() == 0, "R9 no extra words", beat_t'(exp_q.size()), '0);

    // R1: reset while a word is held
    s_valid = 1'b1; {s_last, s_keep, s_data} = make_beat(0, 1); m_ready = 0;
    @(negedge clk);
    s_valid = 1'b0;
    chk(m_valid == 1'b1, "R3 holding before reset", beat_t'(m_valid), beat_t'(1));
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(s_ready == 1'b1, "R1 s_axis_tready after mid-hold reset", beat_t'(s_ready), beat_t'(1));
    chk(m_valid == 1'b0, "R1 m_axis_tvalid after mid-hold reset", beat_t'(m_valid), beat_t'(0));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule